// File: doc/BRIEF.md
# Conditional Call Stack Controller

This unit performs the subroutine call and return steps of a small virtual-machine core. Each issued instruction comes with a flag that says whether it is a call or a return. It also carries the already evaluated branch decision, the current program counter, the operand A and an 8-bit immediate. A taken call saves the operand and the program counter on an internal stack of parameterised depth. It then sends execution forward by a distance that the low seven bits of the immediate select. A taken return restores the most recently saved pair and resumes at the instruction after the saved program counter.

When the branch decision is false, neither operation moves control. Both degrade to a plain move that writes C = A, and execution goes on at the next instruction. Program counters count bytes, and each instruction occupies `INSN_BYTES` (default 16) bytes, so a forward jump spans one to 128 instructions.

A call that finds the stack full, or a return that finds it empty, leaves the stack as it was. It behaves like the not-taken case and raises an error flag for one cycle. All results are registered. They appear in the cycle after the instruction is issued, and the stack changes on that same edge.

Top module: `call_stack_ctrl`

## Requirements
- R1: After reset, `depth` is 0 and `out_valid`, `c_wr`, `jumped`, `ovf_err` and `unf_err` are all 0.
- R2: A taken call (`is_call`=1, `taken`=1) on a non-full stack pushes {`a_in`, `pc_in`}. On the next cycle, `pc_next` = `pc_in` + 16·(`imm8[6:0]`+1), `jumped`=1, `c_wr`=0, and `depth` has grown by one.
- R3: Bit 7 of `imm8` has no effect on the jump distance.
- R4: A call or return issued with `taken`=0 gives on the next cycle `c_wr`=1, `c_data`=`a_in`, `pc_next`=`pc_in`+16 and `jumped`=0, and `depth` does not change.
- R5: A taken return (`is_call`=0, `taken`=1) on a non-empty stack pops the top entry. On the next cycle, `c_data` is the saved value, `pc_next` is the saved pc + 16, `c_wr`=1, `jumped`=1, and `depth` has dropped by one.
- R6: Returns hand back the saved entries in last-in, first-out order.
- R7: A taken call when `depth` equals DEPTH leaves the stack unchanged and is handled as not taken (C = A, pc + 16). `ovf_err` is 1 for exactly the following cycle.
- R8: A taken return when `depth` is 0 leaves the stack empty and is handled as not taken. `unf_err` is 1 for exactly the following cycle.
- R9: `out_valid` is 1 exactly in the cycle after an issue. A cycle without an issue produces no `out_valid`, `jumped` or error flag in the next cycle.
- R10: The largest step (`imm8[6:0]`=127) is 2048 bytes, and the jump target wraps modulo 2^PCW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An instruction is presented this cycle |
| is_call | input | 1 | 1 = call, 0 = return |
| taken | input | 1 | Branch decision from the condition evaluator |
| pc_in | input | PCW | Byte address of the issued instruction |
| a_in | input | DW | Operand A |
| imm8 | input | 8 | Immediate; bits 6:0 set the jump distance |
| out_valid | output | 1 | Result of the previous cycle's issue is present |
| c_wr | output | 1 | Write `c_data` to the destination C |
| c_data | output | DW | Value for C |
| pc_next | output | PCW | Address to fetch next |
| jumped | output | 1 | Control was transferred (call or return taken) |
| ovf_err | output | 1 | One-cycle pulse: call refused, stack full |
| unf_err | output | 1 | One-cycle pulse: return refused, stack empty |
| depth | output | $clog2(DEPTH+1) | Number of entries on the stack |

## Verification
The properties take for granted that `taken` has settled before the clock edge and that `pc_in` and `a_in` are stable while `issue` is high. They also assume that nothing outside the block ever writes the stack. Given that, each property ties an issue in one cycle to the outputs of the next. The bench drives every input at the falling edge and holds `issue` for exactly one cycle per instruction, so each issue in the stimulus maps to a single result cycle. It keeps the stack depth known at every step, so the full and empty corner cases are reached on purpose rather than by chance.

// File: rtl/call_stack_ctrl.sv
module call_stack_ctrl #(
  parameter int DW         = 64,
  parameter int PCW        = 32,
  parameter int DEPTH      = 4,
  parameter int INSN_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue,
  input  logic                       is_call,
  input  logic                       taken,
  input  logic [PCW-1:0]             pc_in,
  input  logic [DW-1:0]              a_in,
  input  logic [7:0]                 imm8,
  output logic                       out_valid,
  output logic                       c_wr,
  output logic [DW-1:0]              c_data,
  output logic [PCW-1:0]             pc_next,
  output logic                       jumped,
  output logic                       ovf_err,
  output logic                       unf_err,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int SPW = $clog2(DEPTH+1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]  val_mem [DEPTH];
  logic [PCW-1:0] pc_mem  [DEPTH];

  logic full, empty, want_push, want_pop, do_push, do_pop;
  logic [IW-1:0]  wr_idx, top_idx;
  logic [PCW-1:0] step, seq_pc, jump_pc;
  logic           unused_imm;

  assign unused_imm = imm8[7];

  assign full    = (depth == SPW'(DEPTH));
  assign empty   = (depth == '0);
  assign wr_idx  = IW'(depth);
  assign top_idx = IW'(depth - SPW'(1));

  assign want_push = issue & is_call & taken;
  assign want_pop  = issue & ~is_call & taken;
  assign do_push   = want_push & ~full;
  assign do_pop    = want_pop & ~empty;

  assign step    = PCW'({1'b0, imm8[6:0]} + 8'd1) * PCW'(INSN_BYTES);
  assign seq_pc  = pc_in + PCW'(INSN_BYTES);
  assign jump_pc = pc_in + step;

  always_ff @(posedge clk) begin
    if (do_push) begin
      val_mem[wr_idx] <= a_in;
      pc_mem[wr_idx]  <= pc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth     <= '0;
      out_valid <= 1'b0;
      c_wr      <= 1'b0;
      c_data    <= '0;
      pc_next   <= '0;
      jumped    <= 1'b0;
      ovf_err   <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      out_valid <= issue;
      c_wr      <= issue & ~do_push;
      jumped    <= do_push | do_pop;
      ovf_err   <= want_push & full;
      unf_err   <= want_pop & empty;
      if (issue) begin
        c_data <= do_pop ? val_mem[top_idx] : a_in;
        if (do_push)     pc_next <= jump_pc;
        else if (do_pop) pc_next <= pc_mem[top_idx] + PCW'(INSN_BYTES);
        else             pc_next <= seq_pc;
      end
      if (do_push)     depth <= depth + SPW'(1);
      else if (do_pop) depth <= depth - SPW'(1);
    end
  end
endmodule

// File: rtl/call_stack_ctrl_chk.sv
module call_stack_ctrl_chk #(
  parameter int DW    = 64,
  parameter int PCW   = 32,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       issue,
  input logic                       is_call,
  input logic                       taken,
  input logic [PCW-1:0]             pc_in,
  input logic [DW-1:0]              a_in,
  input logic [7:0]                 imm8,
  input logic                       out_valid,
  input logic                       c_wr,
  input logic [DW-1:0]              c_data,
  input logic [PCW-1:0]             pc_next,
  input logic                       jumped,
  input logic                       ovf_err,
  input logic                       unf_err,
  input logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int SPW = $clog2(DEPTH+1);

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_call && taken && depth != SPW'(DEPTH) |=> jumped && !c_wr && depth == $past(depth) + SPW'(1)); // R2

  AST_TARGET_LOW7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_call && taken && depth != SPW'(DEPTH) |=> pc_next == $past(pc_in) + PCW'(({1'b0, $past(imm8[6:0])} + 8'd1) * 8'd16) ); // R3

  AST_NOT_TAKEN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !taken |=> c_wr && !jumped && c_data == $past(a_in) && depth == $past(depth)); // R4

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_call && taken && depth != '0 |=> jumped && c_wr && depth == $past(depth) - SPW'(1)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_call && taken && depth == SPW'(DEPTH) |=> ovf_err && !jumped && depth == SPW'(DEPTH)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_call && taken && depth == '0 |=> unf_err && !jumped && depth == '0); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !out_valid && !jumped && !ovf_err && !unf_err); // R9

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_err, unf_err, jumped}) <= 1); // R7

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SPW'(DEPTH)); // R6
endmodule

bind call_stack_ctrl call_stack_ctrl_chk #(.DW(DW), .PCW(PCW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .is_call(is_call), .taken(taken),
  .pc_in(pc_in), .a_in(a_in), .imm8(imm8), .out_valid(out_valid), .c_wr(c_wr),
  .c_data(c_data), .pc_next(pc_next), .jumped(jumped), .ovf_err(ovf_err),
  .unf_err(unf_err), .depth(depth)
);

// File: tb/call_stack_ctrl_test.sv
`timescale 1ns/1ps
module call_stack_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0, is_call = 1'b0, taken = 1'b0;
  logic [31:0] pc_in = '0;
  logic [63:0] a_in = '0;
  logic [7:0]  imm8 = '0;
  logic        out_valid, c_wr, jumped, ovf_err, unf_err;
  logic [63:0] c_data;
  logic [31:0] pc_next;
  logic [2:0]  depth;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  call_stack_ctrl uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .is_call(is_call), .taken(taken),
    .pc_in(pc_in), .a_in(a_in), .imm8(imm8), .out_valid(out_valid), .c_wr(c_wr),
    .c_data(c_data), .pc_next(pc_next), .jumped(jumped), .ovf_err(ovf_err),
    .unf_err(unf_err), .depth(depth)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic call, input logic tk, input logic [31:0] pc,
                    input logic [63:0] a, input logic [7:0] imm);
    issue = 1'b1; is_call = call; taken = tk; pc_in = pc; a_in = a; imm8 = imm;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 depth", depth, 0);
    chk("R1 flags", {out_valid, c_wr, jumped, ovf_err, unf_err}, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R9 idle flags", {out_valid, jumped, ovf_err, unf_err}, 0);
  endtask

  task automatic t_underflow;
    op(1'b0, 1'b1, 32'h300, 64'h5555, 8'h10);
    chk("R8 unf", unf_err, 1);
    chk("R8 c_data", c_data, 64'h5555);
    chk("R8 pc", pc_next, 32'h310);
    chk("R8 depth", depth, 0);
    chk("R9 valid", out_valid, 1);
    @(negedge clk);
    chk("R8 pulse", unf_err, 0);
  endtask

  task automatic t_call;
    op(1'b1, 1'b1, 32'h100, 64'h1111_2222_3333_4444, 8'h05);
    chk("R2 pc", pc_next, 32'h160);
    chk("R2 flags", {jumped, c_wr}, 2'b10);
    chk("R2 depth", depth, 1);
    op(1'b1, 1'b1, 32'h200, 64'hAAAA_BBBB_CCCC_DDDD, 8'h85);
    chk("R3 pc", pc_next, 32'h260);
    chk("R3 depth", depth, 2);
  endtask

  task automatic t_not_taken;
    op(1'b1, 1'b0, 32'h400, 64'h77, 8'h7F);
    chk("R4 call c_data", c_data, 64'h77);
    chk("R4 call flags", {c_wr, jumped}, 2'b10);
    chk("R4 call pc", pc_next, 32'h410);
    chk("R4 call depth", depth, 2);
    op(1'b0, 1'b0, 32'h500, 64'h88, 8'h00);
    chk("R4 ret c_data", c_data, 64'h88);
    chk("R4 ret pc", pc_next, 32'h510);
    chk("R4 ret depth", depth, 2);
  endtask

  task automatic t_returns;
    op(1'b0, 1'b1, 32'h900, 64'h99, 8'h00);
    chk("R5 c_data", c_data, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R5 pc", pc_next, 32'h210);
    chk("R5 flags", {c_wr, jumped}, 2'b11);
    chk("R5 depth", depth, 1);
    op(1'b0, 1'b1, 32'h900, 64'h99, 8'h00);
    chk("R6 c_data", c_data, 64'h1111_2222_3333_4444);
    chk("R6 pc", pc_next, 32'h110);
    chk("R6 depth", depth, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4; i++)
      op(1'b1, 1'b1, 32'h1000 + 32'(i) * 32'h10, 64'hC0DE_0000 + 64'(i), 8'(i));
    chk("R7 fill", depth, 4);
    op(1'b1, 1'b1, 32'h2000, 64'hBAD, 8'h01);
    chk("R7 ovf", ovf_err, 1);
    chk("R7 c_data", c_data, 64'hBAD);
    chk("R7 pc", pc_next, 32'h2010);
    chk("R7 flags", {c_wr, jumped}, 2'b10);
    chk("R7 depth", depth, 4);
    @(negedge clk);
    chk("R7 pulse", ovf_err, 0);
    for (int i = 3; i >= 0; i--) begin
      op(1'b0, 1'b1, 32'h0, 64'h0, 8'h00);
      chk("R6 drain data", c_data, 64'hC0DE_0000 + 64'(i));
      chk("R6 drain pc", pc_next, 32'h1010 + 32'(i) * 32'h10);
    end
    chk("R6 drained", depth, 0);
  endtask

  task automatic t_max_jump;
    op(1'b1, 1'b1, 32'hFFFF_FF00, 64'h42, 8'hFF);
    chk("R10 wrap pc", pc_next, 32'h0000_0700);
    op(1'b1, 1'b1, 32'h40, 64'h43, 8'h7F);
    chk("R10 max pc", pc_next, 32'h840);
    op(1'b0, 1'b1, 32'h0, 64'h0, 8'h00);
    op(1'b0, 1'b1, 32'h0, 64'h0, 8'h00);
    chk("R10 saved pc", pc_next, 32'hFFFF_FF10);
    chk("R10 saved data", c_data, 64'h42);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_underflow();
    t_call();
    t_not_taken();
    t_returns();
    t_overflow();
    t_max_jump();
    t_idle();
    finish_run();
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule